// File: doc/BRIEF.md
# Pseudo-Random Density Pulse Generator

This block produces a single-bit pulse stream whose long-run density of ones is set by a duty word, but whose ones are scattered in a noise-like order instead of being grouped into one contiguous burst per period. A maximal-length linear feedback shift register steps through every nonzero value of its width once per sequence. A magnitude comparator raises the output on each step where the register value does not exceed the held duty word. Because the register visits each value from 1 to N exactly once per sequence (N = 2^WIDTH - 1), the number of high cycles in every sequence equals the duty word. Energy that a ramp-based modulator would put at its lowest repetition frequency is therefore spread across the band, and a downstream low-pass filter has less work to do.

The duty word is captured only on the first enabled cycle of each sequence, so a sequence never mixes two duty values and its count of ones is always exact. Reset loads a nonzero start value taken from a parameter. A zero parameter is replaced by 1. The enable input pauses the generator: while it is low, the register holds its value and the output stays low.

Top module: `rand_pwm`

## Requirements
- R1: While reset is held and in the first cycle after it, `pulse_out` is 0. The generator restarts from its start value, which is 1 by default. With a duty word of 1, the first enabled cycle after reset therefore gives a 1, and the next N-1 enabled cycles give 0.
- R2: For any duty word W with 0 <= W <= N, every sequence of N consecutive enabled cycles after reset contains exactly W ones on `pulse_out`.
- R3: With a duty word of 0, `pulse_out` stays 0 on every enabled cycle.
- R4: With a duty word of N (all ones), `pulse_out` stays 1 on every enabled cycle.
- R5: The duty word is sampled only on the first enabled cycle of a sequence. A value present on that cycle governs the whole sequence. Changes made on any later cycle of the sequence take effect only from the next sequence.
- R6: A cycle with `enable` low gives 0 on `pulse_out` one cycle later and does not advance the sequence. Disabled cycles, including disabled cycles at a sequence boundary, neither change the count of ones in a sequence nor capture a duty word.
- R7: The register never reaches the all-zero state and returns to its start value after exactly N enabled cycles. With a duty word of 1, consecutive ones on `pulse_out` are therefore exactly N enabled cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Advances the generator by one step per cycle when high |
| duty_w | input | WIDTH | Requested number of ones per sequence, 0 to N |
| pulse_out | output | 1 | Registered pseudo-random pulse stream |

## Verification
Two functions can act in the same cycle: the capture of a new duty word at the first step of a sequence, and the comparison that uses that word for the very step on which it is captured. The bench changes the duty word exactly on a sequence's opening cycle and again one cycle later. It then checks that the first value sets the count of ones for that whole sequence and that the second value takes over only in the following sequence. It also drops `enable` on the boundary cycle while a different duty word is presented, and checks that this word is not taken. The word present when `enable` returns is the one that must set the next count.

// File: rtl/rpwm_pkg.sv
package rpwm_pkg;

  // Feedback mask for a shift-left Fibonacci register: bit k-1 set for term x^k.
  function automatic logic [31:0] tap_mask(input int unsigned width);
    logic [31:0] m;
    case (width)
      3:       m = 32'h0000_0006;
      4:       m = 32'h0000_000C;
      5:       m = 32'h0000_0014;
      6:       m = 32'h0000_0030;
      7:       m = 32'h0000_0060;
      8:       m = 32'h0000_00B8;
      9:       m = 32'h0000_0110;
      10:      m = 32'h0000_0240;
      11:      m = 32'h0000_0500;
      12:      m = 32'h0000_0E08;
      13:      m = 32'h0000_1C80;
      14:      m = 32'h0000_3802;
      15:      m = 32'h0000_6000;
      16:      m = 32'h0000_D008;
      default: m = 32'h0000_00B8;
    endcase
    return m;
  endfunction

  // Number of distinct nonzero states visited per sequence.
  function automatic int unsigned seq_len(input int unsigned width);
    return (32'd1 << width) - 32'd1;
  endfunction

  // Start value with the forbidden all-zero state replaced by 1.
  function automatic logic [31:0] legal_seed(input int unsigned width,
                                             input logic [31:0] seed);
    logic [31:0] kept;
    kept = seed & ((32'd1 << width) - 32'd1);
    return (kept == 32'd0) ? 32'd1 : kept;
  endfunction

  // A step is high when the state, counted from 1, does not exceed the duty word.
  function automatic logic duty_hit(input logic [31:0] state,
                                    input logic [31:0] duty);
    return state <= duty;
  endfunction

endpackage

// File: rtl/rpwm_lfsr.sv
module rpwm_lfsr #(
  parameter int unsigned WIDTH = 8,
  parameter logic [31:0] SEED  = 32'd1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  output logic [WIDTH-1:0] state,
  output logic             at_start
);
  localparam logic [WIDTH-1:0] MASK  = WIDTH'(rpwm_pkg::tap_mask(WIDTH));
  localparam logic [WIDTH-1:0] START = WIDTH'(rpwm_pkg::legal_seed(WIDTH, SEED));

  logic             feedback;
  logic [WIDTH-1:0] next_state;

  always_comb begin
    feedback   = ^(state & MASK);
    next_state = {state[WIDTH-2:0], feedback};
  end

  always_ff @(posedge clk) begin
    if (rst)          state <= START;
    else if (advance) state <= next_state;
  end

  assign at_start = (state == START);
endmodule

// File: rtl/rpwm_duty_hold.sv
module rpwm_duty_hold #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [WIDTH-1:0] duty_in,
  output logic [WIDTH-1:0] duty_held,
  output logic [WIDTH-1:0] duty_live
);
  always_ff @(posedge clk) begin
    if (rst)          duty_held <= '0;
    else if (capture) duty_held <= duty_in;
  end

  // The opening step of a sequence already compares against the new word.
  assign duty_live = capture ? duty_in : duty_held;
endmodule

// File: rtl/rpwm_cmp.sv
module rpwm_cmp #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  input  logic [WIDTH-1:0] state,
  input  logic [WIDTH-1:0] duty,
  output logic             pulse
);
  logic hit;

  assign hit = rpwm_pkg::duty_hit(32'(state), 32'(duty));

  always_ff @(posedge clk) begin
    if (rst) pulse <= 1'b0;
    else     pulse <= advance & hit;
  end
endmodule

// File: rtl/rand_pwm.sv
module rand_pwm #(
  parameter int unsigned WIDTH = 8,
  parameter logic [31:0] SEED  = 32'd1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [WIDTH-1:0] duty_w,
  output logic             pulse_out
);
  logic [WIDTH-1:0] lfsr_state;
  logic             seq_start;
  logic             take_duty;
  logic [WIDTH-1:0] duty_held;
  logic [WIDTH-1:0] duty_live;

  assign take_duty = enable & seq_start;

  rpwm_lfsr #(.WIDTH(WIDTH), .SEED(SEED)) u_lfsr (
    .clk      (clk),
    .rst      (rst),
    .advance  (enable),
    .state    (lfsr_state),
    .at_start (seq_start)
  );

  rpwm_duty_hold #(.WIDTH(WIDTH)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .capture   (take_duty),
    .duty_in   (duty_w),
    .duty_held (duty_held),
    .duty_live (duty_live)
  );

  rpwm_cmp #(.WIDTH(WIDTH)) u_cmp (
    .clk     (clk),
    .rst     (rst),
    .advance (enable),
    .state   (lfsr_state),
    .duty    (duty_live),
    .pulse   (pulse_out)
  );
endmodule

// File: rtl/rand_pwm_chk.sv
module rand_pwm_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             pulse_out,
  input logic [WIDTH-1:0] lfsr_state,
  input logic             seq_start,
  input logic             take_duty,
  input logic [WIDTH-1:0] duty_held,
  input logic [WIDTH-1:0] duty_live
);
  localparam logic [WIDTH-1:0] LAST = WIDTH'(rpwm_pkg::seq_len(WIDTH) - 1);
  localparam logic [WIDTH-1:0] FULL = WIDTH'(rpwm_pkg::seq_len(WIDTH));

  // Independent step counter: the sequence must restart exactly every N steps.
  logic [WIDTH-1:0] step_cnt;
  always_ff @(posedge clk) begin
    if (rst)         step_cnt <= '0;
    else if (enable) step_cnt <= (step_cnt == LAST) ? '0 : step_cnt + 1'b1;
  end

  assert_state_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
    lfsr_state != '0);

  assert_period_R7: assert property (@(posedge clk) disable iff (rst)
    (step_cnt == '0) == seq_start);

  assert_hold_only_at_start_R5: assert property (@(posedge clk) disable iff (rst)
    !take_duty |=> $stable(duty_held));

  assert_idle_low_R6: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !pulse_out);

  assert_idle_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(lfsr_state));

  assert_zero_duty_R3: assert property (@(posedge clk) disable iff (rst)
    (enable && duty_live == '0) |=> !pulse_out);

  assert_full_duty_R4: assert property (@(posedge clk) disable iff (rst)
    (enable && duty_live == FULL) |=> pulse_out);
endmodule

bind rand_pwm rand_pwm_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .enable     (enable),
  .pulse_out  (pulse_out),
  .lfsr_state (lfsr_state),
  .seq_start  (seq_start),
  .take_duty  (take_duty),
  .duty_held  (duty_held),
  .duty_live  (duty_live)
);

// File: tb/rand_pwm_tb.sv
`timescale 1ns/1ps
module rand_pwm_tb;
  localparam int WIDTH = 8;
  localparam int N     = 255;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             enable = 1'b0;
  logic [WIDTH-1:0] duty_w = '0;
  logic             pulse_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rand_pwm #(.WIDTH(WIDTH)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .duty_w    (duty_w),
    .pulse_out (pulse_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One clock edge; returns the output as seen just after it.
  task automatic step(output logic p);
    @(posedge clk);
    #1;
    p = pulse_out;
  endtask

  task automatic do_reset();
    logic p;
    rst = 1'b1;
    enable = 1'b0;
    repeat (3) step(p);
    check(p == 1'b0, "R1", int'(p), 0);
    rst = 1'b0;
  endtask

  // One full sequence at a fixed duty word; returns the count of ones.
  task automatic run_window(input int w, output int ones);
    logic p;
    ones = 0;
    duty_w = WIDTH'(w);
    enable = 1'b1;
    for (int i = 0; i < N; i++) begin
      step(p);
      ones += int'(p);
    end
  endtask

  task automatic test_reset_r1();
    logic p;
    int   late;
    do_reset();
    duty_w = 8'd1;
    step(p);
    check(p == 1'b0, "R1", int'(p), 0);
    enable = 1'b1;
    step(p);
    check(p == 1'b1, "R1", int'(p), 1);
    late = 0;
    for (int i = 1; i < N; i++) begin
      step(p);
      late += int'(p);
    end
    check(late == 0, "R1", late, 0);
  endtask

  task automatic test_counts_r2();
    int vals[6] = '{1, 2, 37, 128, 200, 254};
    int ones;
    do_reset();
    foreach (vals[k]) begin
      run_window(vals[k], ones);
      check(ones == vals[k], "R2", ones, vals[k]);
    end
  endtask

  task automatic test_extremes_r3_r4();
    int ones;
    do_reset();
    run_window(0, ones);
    check(ones == 0, "R3", ones, 0);
    run_window(0, ones);
    check(ones == 0, "R3", ones, 0);
    run_window(N, ones);
    check(ones == N, "R4", ones, N);
    run_window(N, ones);
    check(ones == N, "R4", ones, N);
  endtask

  task automatic test_capture_r5();
    logic p;
    int   ones;
    do_reset();
    // Change late in the sequence: must not affect it.
    duty_w = 8'd10;
    enable = 1'b1;
    ones = 0;
    for (int i = 0; i < N; i++) begin
      if (i == 50) duty_w = 8'd200;
      step(p);
      ones += int'(p);
    end
    check(ones == 10, "R5", ones, 10);
    run_window(200, ones);
    check(ones == 200, "R5", ones, 200);
    // New word exactly on the opening cycle, another one cycle later.
    ones = 0;
    for (int i = 0; i < N; i++) begin
      if (i == 0) duty_w = 8'd30;
      if (i == 1) duty_w = 8'd90;
      step(p);
      ones += int'(p);
    end
    check(ones == 30, "R5", ones, 30);
    run_window(90, ones);
    check(ones == 90, "R5", ones, 90);
  endtask

  task automatic test_enable_r6();
    logic p;
    int   ones;
    int   active;
    int   idle_high;
    bit   was_idle;
    do_reset();
    duty_w = 8'd100;
    ones = 0;
    active = 0;
    idle_high = 0;
    for (int k = 0; active < N; k++) begin
      was_idle = (k % 5 == 2);
      enable = !was_idle;
      step(p);
      if (was_idle) idle_high += int'(p);
      else begin
        ones += int'(p);
        active++;
      end
    end
    check(idle_high == 0, "R6", idle_high, 0);
    check(ones == 100, "R6", ones, 100);
    // Idle at the boundary while a different word is presented.
    enable = 1'b0;
    duty_w = 8'd77;
    idle_high = 0;
    for (int i = 0; i < 3; i++) begin
      step(p);
      idle_high += int'(p);
    end
    check(idle_high == 0, "R6", idle_high, 0);
    run_window(55, ones);
    check(ones == 55, "R6", ones, 55);
  endtask

  task automatic test_period_r7();
    logic p;
    int   last_hit;
    int   hits;
    int   bad_gap;
    do_reset();
    duty_w = 8'd1;
    enable = 1'b1;
    last_hit = -1;
    hits = 0;
    bad_gap = 0;
    for (int i = 0; i < 3 * N; i++) begin
      step(p);
      if (p) begin
        if (last_hit >= 0 && (i - last_hit) != N) bad_gap++;
        last_hit = i;
        hits++;
      end
    end
    check(hits == 3, "R7", hits, 3);
    check(bad_gap == 0, "R7", bad_gap, 0);
  endtask

  initial begin
    test_reset_r1();
    test_counts_r2();
    test_extremes_r3_r4();
    test_capture_r5();
    test_enable_r6();
    test_period_r7();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule